// File: doc/BRIEF.md
# Triggered ADC Latency Pipeline

This block sits behind the deserializers of a multi-channel digitizer board. Each channel delivers its 12-bit samples as pairs of 6-bit halves, six samples per beam crossing. The block rebuilds the samples and holds them in a per-channel circular delay line whose tap is set so that the sample leaving the line belongs to the crossing the first-level trigger refers to. The trigger arrives 40 crossings (240 samples) late.

When a trigger is accepted, a capture state machine copies a window of delayed samples from every channel into one of eight event slots. A readout state machine drains full slots oldest first through a valid/ready port: a header word carrying the event number, then the samples ordered by channel and, within a channel, by time. In parallel, each rebuilt sample is compared against seven thresholds per channel, and the result is given as a 3-bit level that feeds the trigger logic.

The capture machine has two states. CAP_IDLE goes to CAP_RUN on an accepted trigger. CAP_RUN goes back to CAP_IDLE when the last sample of the window has been stored. The readout machine has three states. RD_IDLE goes to RD_HEAD when at least one complete event is held. RD_HEAD goes to RD_BODY when the header is accepted. RD_BODY goes back to RD_IDLE when the last sample word is accepted.

Top module: `lp_trig_pipe`

## Requirements
- R1: A sample is formed from two accepted halves (`half_vld_i` high). The first half gives bits 5:0 and the second gives bits 11:6 of every channel. Idle cycles between the halves do not disturb the pairing.
- R2: `level_o[3c+2:3c]` equals the number of channel c's seven thresholds that the latest sample of channel c strictly exceeds. Threshold l of channel c is `thr_i[(7c+l)*12 +: 12]`. The level updates two clock cycles after the second half is accepted.
- R3: With delay D (1..255), the t-th captured sample of an event is the sample that arrived D samples before the (t+1)-th sample strobe following the trigger cycle. Each channel's stored value is therefore sample index (first index after trigger) + t - D.
- R4: The window length per event is `win_i` sampled when the trigger is accepted. A value of 0 is taken as 1, and any value above 24 is taken as 24.
- R5: An event is read as one header word `{1'b1, 3'b000, event_number[11:0]}` followed by `{4'b0000, sample[11:0]}` words. The order is channel 0 times 0..W-1, then channel 1, and so on. `rd_last_o` is high only on the final word.
- R6: Event numbers start at 0 after reset and increase by one for each accepted trigger, wrapping at 12 bits.
- R7: Up to 8 events are held at once, and they are read out in the order of their triggers.
- R8: `busy_o` is high exactly when the number of complete events plus the event being captured equals 8.
- R9: A trigger that arrives while no capture is running and 8 events are held is dropped. It increments `drop_cnt_o` by one, and the counter saturates at 255.
- R10: A trigger that arrives while a capture is running is ignored. It creates no event and does not change `drop_cnt_o`.
- R11: While `rd_valid_o` is high and `rd_ready_i` is low, `rd_valid_o`, `rd_data_o` and `rd_last_o` hold their values.
- R12: After reset, `rd_valid_o`, `busy_o`, `drop_cnt_o` and `level_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| half_vld_i | input | 1 | Half-sample strobe, common to all channels |
| half_i | input | NCH*6 | 6-bit half sample per channel |
| trig_i | input | 1 | First-level trigger strobe |
| delay_i | input | 8 | Delay-line tap distance in samples |
| win_i | input | 5 | Capture window length in samples |
| thr_i | input | NCH*7*12 | Seven thresholds per channel |
| level_o | output | NCH*3 | Per-channel threshold level |
| rd_valid_o | output | 1 | Readout word valid |
| rd_ready_i | input | 1 | Readout consumer ready |
| rd_data_o | output | 16 | Readout word |
| rd_last_o | output | 1 | Final word of an event |
| busy_o | output | 1 | No free event slot |
| drop_cnt_o | output | 8 | Count of triggers dropped while full |

## Verification
A wrong write pointer or tap offset in the delay line shows in the first sample word of the next event read out. That word has a value whose sample index is shifted. A broken half pairing shows in the level output two cycles after the sample. If the slot pointers or the occupancy count go wrong, the effect appears at the ports only once events are stacked. Events then come out of order or carry duplicate numbers. `busy_o` and the drop counter stop matching the number of triggers while the slots are full. For this reason the slots are filled to the limit with the readout stalled, and then drained.

// File: rtl/lp_pkg.sv
package lp_pkg;
    localparam int SMP_W  = 12;
    localparam int HALF_W = SMP_W / 2;
    localparam int NLVL   = 7;
    localparam int LVL_W  = $clog2(NLVL + 1);
    localparam int WORD_W = SMP_W + 4;

    typedef enum logic [0:0] {
        CAP_IDLE,
        CAP_RUN
    } cap_state_t;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_HEAD,
        RD_BODY
    } rd_state_t;
endpackage

// File: rtl/lp_half_merge.sv
module lp_half_merge
    import lp_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  half_vld_i,
    input  logic [NCH*HALF_W-1:0] half_i,
    output logic                  smp_vld_o,
    output logic [NCH*SMP_W-1:0]  smp_o
);
    logic                  phase_q;
    logic                  vld_q;
    logic [NCH*HALF_W-1:0] lo_q;
    logic [NCH*SMP_W-1:0]  smp_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            phase_q <= 1'b0;
            vld_q   <= 1'b0;
            lo_q    <= '0;
            smp_q   <= '0;
        end else begin
            vld_q <= 1'b0;
            if (half_vld_i) begin
                if (!phase_q) begin
                    lo_q    <= half_i;
                    phase_q <= 1'b1;
                end else begin
                    for (int c = 0; c < NCH; c++) begin
                        smp_q[c*SMP_W +: SMP_W] <= {half_i[c*HALF_W +: HALF_W],
                                                    lo_q[c*HALF_W +: HALF_W]};
                    end
                    vld_q   <= 1'b1;
                    phase_q <= 1'b0;
                end
            end
        end
    end

    assign smp_vld_o = vld_q;
    assign smp_o     = smp_q;
endmodule

// File: rtl/lp_level_enc.sv
module lp_level_enc
    import lp_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      smp_vld_i,
    input  logic [NCH*SMP_W-1:0]      smp_i,
    input  logic [NCH*NLVL*SMP_W-1:0] thr_i,
    output logic [NCH*LVL_W-1:0]      level_o
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [LVL_W-1:0] cnt;
        logic [LVL_W-1:0] lvl_q;

        always_comb begin
            cnt = '0;
            for (int l = 0; l < NLVL; l++) begin
                if (smp_i[c*SMP_W +: SMP_W] > thr_i[(c*NLVL+l)*SMP_W +: SMP_W]) begin
                    cnt = cnt + 1'b1;
                end
            end
        end

        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                lvl_q <= '0;
            end else if (smp_vld_i) begin
                lvl_q <= cnt;
            end
        end

        assign level_o[c*LVL_W +: LVL_W] = lvl_q;
    end
endmodule

// File: rtl/lp_delay_ring.sv
module lp_delay_ring
    import lp_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int DEPTH = 256,
    localparam int DLY_W = $clog2(DEPTH)
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 smp_vld_i,
    input  logic [NCH*SMP_W-1:0] smp_i,
    input  logic [DLY_W-1:0]     delay_i,
    output logic [NCH*SMP_W-1:0] tap_o
);
    logic [SMP_W-1:0] mem [NCH][DEPTH];
    logic [DLY_W-1:0] wp_q;
    logic [DLY_W-1:0] rd_addr;

    assign rd_addr = wp_q - delay_i;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            wp_q <= '0;
        end else if (smp_vld_i) begin
            wp_q <= wp_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (smp_vld_i) begin
            for (int c = 0; c < NCH; c++) begin
                mem[c][wp_q] <= smp_i[c*SMP_W +: SMP_W];
            end
        end
    end

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            tap_o[c*SMP_W +: SMP_W] = mem[c][rd_addr];
        end
    end
endmodule

// File: rtl/lp_event_store.sv
module lp_event_store
    import lp_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int NSLOT   = 8,
    parameter int WIN_MAX = 24,
    parameter int DROP_W  = 8,
    localparam int WIN_W  = $clog2(WIN_MAX + 1),
    localparam int SL_W   = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int CNT_W  = $clog2(NSLOT + 1),
    localparam int CH_W   = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int BA_W   = $clog2(NSLOT * WIN_MAX)
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 smp_vld_i,
    input  logic [NCH*SMP_W-1:0] tap_i,
    input  logic                 trig_i,
    input  logic [WIN_W-1:0]     win_i,
    output logic                 rd_valid_o,
    input  logic                 rd_ready_i,
    output logic [WORD_W-1:0]    rd_data_o,
    output logic                 rd_last_o,
    output logic                 busy_o,
    output logic [DROP_W-1:0]    drop_cnt_o
);
    cap_state_t cap_q, cap_d;
    rd_state_t  rd_q, rd_d;

    logic [SMP_W-1:0] evbuf [NCH][NSLOT*WIN_MAX];
    logic [WIN_W-1:0] slot_win [NSLOT];
    logic [SMP_W-1:0] slot_ev  [NSLOT];

    logic [WIN_W-1:0]  cap_t_q, cap_win_q, win_eff;
    logic [SL_W-1:0]   wr_slot_q, rd_slot_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [SMP_W-1:0]  evnum_q;
    logic [DROP_W-1:0] drop_q;
    logic [CH_W-1:0]   rd_ch_q;
    logic [WIN_W-1:0]  rd_t_q, cur_win;
    logic [CNT_W:0]    occ;
    logic [BA_W-1:0]   wr_addr, rd_addr;
    logic accept, drop_ev, cap_done, rd_done, body_last;

    // Window clamp
    always_comb begin
        if (win_i == '0) begin
            win_eff = WIN_W'(1);
        end else if (int'(win_i) > WIN_MAX) begin
            win_eff = WIN_W'(WIN_MAX);
        end else begin
            win_eff = win_i;
        end
    end

    assign accept   = (cap_q == CAP_IDLE) && trig_i && (int'(cnt_q) < NSLOT);
    assign drop_ev  = (cap_q == CAP_IDLE) && trig_i && (int'(cnt_q) == NSLOT);
    assign cap_done = (cap_q == CAP_RUN) && smp_vld_i && (cap_t_q == cap_win_q - 1'b1);
    assign occ      = {1'b0, cnt_q} + ((cap_q == CAP_RUN) ? 1 : 0);
    assign busy_o   = (int'(occ) == NSLOT);
    assign drop_cnt_o = drop_q;

    assign cur_win   = slot_win[rd_slot_q];
    assign body_last = (rd_ch_q == CH_W'(NCH - 1)) && (rd_t_q == cur_win - 1'b1);
    assign rd_done   = (rd_q == RD_BODY) && rd_ready_i && body_last;

    assign wr_addr = BA_W'(int'(wr_slot_q) * WIN_MAX + int'(cap_t_q));
    assign rd_addr = BA_W'(int'(rd_slot_q) * WIN_MAX + int'(rd_t_q));

    // Capture state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) cap_q <= CAP_IDLE;
        else         cap_q <= cap_d;
    end

    always_comb begin
        cap_d = cap_q;
        unique case (cap_q)
            CAP_IDLE: if (accept)   cap_d = CAP_RUN;
            CAP_RUN:  if (cap_done) cap_d = CAP_IDLE;
            default:  cap_d = CAP_IDLE;
        endcase
    end

    // Readout state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) rd_q <= RD_IDLE;
        else         rd_q <= rd_d;
    end

    always_comb begin
        rd_d = rd_q;
        unique case (rd_q)
            RD_IDLE: if (cnt_q != '0) rd_d = RD_HEAD;
            RD_HEAD: if (rd_ready_i)  rd_d = RD_BODY;
            RD_BODY: if (rd_done)     rd_d = RD_IDLE;
            default: rd_d = RD_IDLE;
        endcase
    end

    // Readout outputs
    always_comb begin
        rd_valid_o = 1'b0;
        rd_data_o  = '0;
        rd_last_o  = 1'b0;
        unique case (rd_q)
            RD_IDLE: ;
            RD_HEAD: begin
                rd_valid_o = 1'b1;
                rd_data_o  = {4'b1000, slot_ev[rd_slot_q]};
            end
            RD_BODY: begin
                rd_valid_o = 1'b1;
                rd_data_o  = {4'b0000, evbuf[rd_ch_q][rd_addr]};
                rd_last_o  = body_last;
            end
            default: ;
        endcase
    end

    // Sample storage
    always_ff @(posedge clk_i) begin
        if ((cap_q == CAP_RUN) && smp_vld_i) begin
            for (int c = 0; c < NCH; c++) begin
                evbuf[c][wr_addr] <= tap_i[c*SMP_W +: SMP_W];
            end
        end
    end

    // Control datapath
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cap_t_q   <= '0;
            cap_win_q <= WIN_W'(1);
            wr_slot_q <= '0;
            rd_slot_q <= '0;
            cnt_q     <= '0;
            evnum_q   <= '0;
            drop_q    <= '0;
            rd_ch_q   <= '0;
            rd_t_q    <= '0;
            for (int s = 0; s < NSLOT; s++) begin
                slot_win[s] <= WIN_W'(1);
                slot_ev[s]  <= '0;
            end
        end else begin
            if (accept) begin
                cap_t_q             <= '0;
                cap_win_q           <= win_eff;
                slot_win[wr_slot_q] <= win_eff;
                slot_ev[wr_slot_q]  <= evnum_q;
                evnum_q             <= evnum_q + 1'b1;
            end else if ((cap_q == CAP_RUN) && smp_vld_i) begin
                cap_t_q <= cap_t_q + 1'b1;
            end

            if (cap_done) begin
                wr_slot_q <= (int'(wr_slot_q) == NSLOT - 1) ? '0 : wr_slot_q + 1'b1;
            end

            if (drop_ev && (drop_q != '1)) begin
                drop_q <= drop_q + 1'b1;
            end

            if (cap_done && !rd_done) begin
                cnt_q <= cnt_q + 1'b1;
            end else if (!cap_done && rd_done) begin
                cnt_q <= cnt_q - 1'b1;
            end

            if ((rd_q == RD_HEAD) && rd_ready_i) begin
                rd_ch_q <= '0;
                rd_t_q  <= '0;
            end else if ((rd_q == RD_BODY) && rd_ready_i) begin
                if (rd_t_q == cur_win - 1'b1) begin
                    rd_t_q  <= '0;
                    rd_ch_q <= rd_ch_q + 1'b1;
                end else begin
                    rd_t_q <= rd_t_q + 1'b1;
                end
            end

            if (rd_done) begin
                rd_slot_q <= (int'(rd_slot_q) == NSLOT - 1) ? '0 : rd_slot_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lp_trig_pipe.sv
module lp_trig_pipe
    import lp_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int DEPTH   = 256,
    parameter int NSLOT   = 8,
    parameter int WIN_MAX = 24,
    parameter int DROP_W  = 8,
    localparam int DLY_W  = $clog2(DEPTH),
    localparam int WIN_W  = $clog2(WIN_MAX + 1)
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      half_vld_i,
    input  logic [NCH*HALF_W-1:0]     half_i,
    input  logic                      trig_i,
    input  logic [DLY_W-1:0]          delay_i,
    input  logic [WIN_W-1:0]          win_i,
    input  logic [NCH*NLVL*SMP_W-1:0] thr_i,
    output logic [NCH*LVL_W-1:0]      level_o,
    output logic                      rd_valid_o,
    input  logic                      rd_ready_i,
    output logic [WORD_W-1:0]         rd_data_o,
    output logic                      rd_last_o,
    output logic                      busy_o,
    output logic [DROP_W-1:0]         drop_cnt_o
);
    logic                 smp_vld;
    logic [NCH*SMP_W-1:0] smp;
    logic [NCH*SMP_W-1:0] tap;

    lp_half_merge #(.NCH(NCH)) u_merge (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .half_vld_i(half_vld_i),
        .half_i    (half_i),
        .smp_vld_o (smp_vld),
        .smp_o     (smp)
    );

    lp_level_enc #(.NCH(NCH)) u_level (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .smp_vld_i(smp_vld),
        .smp_i    (smp),
        .thr_i    (thr_i),
        .level_o  (level_o)
    );

    lp_delay_ring #(.NCH(NCH), .DEPTH(DEPTH)) u_ring (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .smp_vld_i(smp_vld),
        .smp_i    (smp),
        .delay_i  (delay_i),
        .tap_o    (tap)
    );

    lp_event_store #(
        .NCH(NCH), .NSLOT(NSLOT), .WIN_MAX(WIN_MAX), .DROP_W(DROP_W)
    ) u_store (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .smp_vld_i (smp_vld),
        .tap_i     (tap),
        .trig_i    (trig_i),
        .win_i     (win_i),
        .rd_valid_o(rd_valid_o),
        .rd_ready_i(rd_ready_i),
        .rd_data_o (rd_data_o),
        .rd_last_o (rd_last_o),
        .busy_o    (busy_o),
        .drop_cnt_o(drop_cnt_o)
    );
endmodule

// File: rtl/lp_trig_pipe_chk.sv
module lp_trig_pipe_chk #(
    parameter int WORD_W = 16,
    parameter int DROP_W = 8,
    parameter int LVL_TW = 12
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              trig_i,
    input logic              rd_valid_o,
    input logic              rd_ready_i,
    input logic [WORD_W-1:0] rd_data_o,
    input logic              rd_last_o,
    input logic              busy_o,
    input logic [DROP_W-1:0] drop_cnt_o,
    input logic [LVL_TW-1:0] level_o
);
    // R11: output word held under back-pressure
    a_r11_hold_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_valid_o && !rd_ready_i) |=>
            (rd_valid_o && $stable(rd_data_o) && $stable(rd_last_o)));

    // R5: last marker only on a presented word
    a_r5_last_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_last_o |-> rd_valid_o);

    // R9: drop counter moves only by one
    a_r9_drop_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (drop_cnt_o != $past(drop_cnt_o)) |-> (drop_cnt_o == $past(drop_cnt_o) + 1'b1));

    // R9: a drop needs a trigger while full
    a_r9_drop_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (drop_cnt_o != $past(drop_cnt_o)) |-> ($past(trig_i) && $past(busy_o)));

    // R9: saturation
    a_r9_drop_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (drop_cnt_o == '1) |=> (drop_cnt_o == '1));

    // R12: quiet outputs out of reset
    a_r12_reset_quiet: assert property (@(posedge clk_i)
        !rst_ni |=> (!rd_valid_o && !busy_o && drop_cnt_o == '0 && level_o == '0));
endmodule

bind lp_trig_pipe lp_trig_pipe_chk #(
    .WORD_W(lp_pkg::WORD_W), .DROP_W(DROP_W), .LVL_TW(NCH*lp_pkg::LVL_W)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .trig_i    (trig_i),
    .rd_valid_o(rd_valid_o),
    .rd_ready_i(rd_ready_i),
    .rd_data_o (rd_data_o),
    .rd_last_o (rd_last_o),
    .busy_o    (busy_o),
    .drop_cnt_o(drop_cnt_o),
    .level_o   (level_o)
);

// File: tb/lp_trig_pipe_tb.sv
`timescale 1ns/1ps
module lp_trig_pipe_tb;
    localparam int NCH = 4;

    logic              clk_i = 1'b0;
    logic              rst_ni;
    logic              half_vld_i;
    logic [NCH*6-1:0]  half_i;
    logic              trig_i;
    logic [7:0]        delay_i;
    logic [4:0]        win_i;
    logic [NCH*84-1:0] thr_i;
    logic [NCH*3-1:0]  level_o;
    logic              rd_valid_o;
    logic              rd_ready_i;
    logic [15:0]       rd_data_o;
    logic              rd_last_o;
    logic              busy_o;
    logic [7:0]        drop_cnt_o;

    int checks = 0;
    int errors = 0;
    int n = 0;
    int ev_exp = 0;
    bit done = 0;

    always #2.5 clk_i = ~clk_i;

    lp_trig_pipe #(.NCH(NCH)) u_dut (
        .clk_i(clk_i), .rst_ni(rst_ni), .half_vld_i(half_vld_i), .half_i(half_i),
        .trig_i(trig_i), .delay_i(delay_i), .win_i(win_i), .thr_i(thr_i),
        .level_o(level_o), .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i),
        .rd_data_o(rd_data_o), .rd_last_o(rd_last_o), .busy_o(busy_o),
        .drop_cnt_o(drop_cnt_o)
    );

    function automatic logic [11:0] fv(int idx, int ch);
        return 12'((idx * 37 + ch * 523 + 5) % 4096);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push_raw(logic [NCH*12-1:0] v, bit gap);
        half_vld_i = 1'b1;
        for (int c = 0; c < NCH; c++) half_i[c*6 +: 6] = v[c*12 +: 6];
        @(negedge clk_i);
        if (gap) begin
            half_vld_i = 1'b0;
            @(negedge clk_i);
        end
        half_vld_i = 1'b1;
        for (int c = 0; c < NCH; c++) half_i[c*6 +: 6] = v[c*12+6 +: 6];
        @(negedge clk_i);
        half_vld_i = 1'b0;
        n++;
    endtask

    task automatic push_std(int cnt);
        for (int k = 0; k < cnt; k++) begin
            logic [NCH*12-1:0] v;
            for (int c = 0; c < NCH; c++) v[c*12 +: 12] = fv(n, c);
            push_raw(v, 1'b0);
        end
    endtask

    task automatic pulse_trig(output int tn);
        @(negedge clk_i);
        @(negedge clk_i);
        trig_i = 1'b1;
        tn = n;
        @(negedge clk_i);
        trig_i = 1'b0;
    endtask

    task automatic read_event(int ev, int tn, int w, int d, bit stall, string req);
        int total = 1 + NCH * w;
        for (int i = 0; i < total; i++) begin
            int to = 0;
            logic [15:0] exp;
            while (!rd_valid_o && to < 300) begin
                @(negedge clk_i);
                to++;
            end
            if (i == 0) exp = {4'b1000, 12'(ev)};
            else exp = {4'b0000, fv(tn + (i-1) % w - d, (i-1) / w)};
            chk(rd_valid_o && rd_data_o == exp, req, int'(rd_data_o), int'(exp));
            chk(rd_last_o == (i == total-1), "R5 last", int'(rd_last_o), int'(i == total-1));
            if (stall) begin
                rd_ready_i = 1'b0;
                @(negedge clk_i);
                chk(rd_valid_o && rd_data_o == exp, "R11 hold", int'(rd_data_o), int'(exp));
            end
            rd_ready_i = 1'b1;
            @(negedge clk_i);
            rd_ready_i = 1'b0;
        end
    endtask

    task automatic t_reset();
        chk(!rd_valid_o, "R12 valid", int'(rd_valid_o), 0);
        chk(!busy_o, "R12 busy", int'(busy_o), 0);
        chk(drop_cnt_o == 0, "R12 drop", int'(drop_cnt_o), 0);
        chk(level_o == 0, "R12 level", int'(level_o), 0);
    endtask

    task automatic t_delay();
        int tn;
        push_std(250);
        delay_i = 8'd40; win_i = 5'd6;
        pulse_trig(tn); push_std(8);
        read_event(ev_exp, tn, 6, 40, 1'b0, "R3 R6 delay40"); ev_exp++;
        delay_i = 8'd240;
        pulse_trig(tn); push_std(8);
        read_event(ev_exp, tn, 6, 240, 1'b1, "R3 R11 delay240"); ev_exp++;
        delay_i = 8'd1;
        pulse_trig(tn); push_std(8);
        read_event(ev_exp, tn, 6, 1, 1'b0, "R3 delay1"); ev_exp++;
    endtask

    task automatic t_window();
        int tn;
        delay_i = 8'd40;
        win_i = 5'd0;
        pulse_trig(tn); push_std(3);
        read_event(ev_exp, tn, 1, 40, 1'b0, "R4 win0"); ev_exp++;
        win_i = 5'd31;
        pulse_trig(tn); push_std(26);
        read_event(ev_exp, tn, 24, 40, 1'b0, "R4 win31"); ev_exp++;
        win_i = 5'd6;
    endtask

    task automatic t_ignore();
        int tn, tn2;
        int d0 = int'(drop_cnt_o);
        pulse_trig(tn); push_std(2);
        pulse_trig(tn2); push_std(6);
        read_event(ev_exp, tn, 6, 40, 1'b0, "R10 first"); ev_exp++;
        repeat (4) @(negedge clk_i);
        chk(!rd_valid_o, "R10 no second event", int'(rd_valid_o), 0);
        chk(int'(drop_cnt_o) == d0, "R10 drop", int'(drop_cnt_o), d0);
    endtask

    task automatic t_overflow();
        int tns [8];
        int dummy;
        int d0 = int'(drop_cnt_o);
        rd_ready_i = 1'b0;
        for (int e = 0; e < 8; e++) begin
            if (e == 7) chk(!busy_o, "R8 seven held", int'(busy_o), 0);
            pulse_trig(tns[e]); push_std(7);
        end
        chk(busy_o, "R8 eight held", int'(busy_o), 1);
        pulse_trig(dummy);
        @(negedge clk_i);
        chk(int'(drop_cnt_o) == d0 + 1, "R9 drop1", int'(drop_cnt_o), d0 + 1);
        pulse_trig(dummy);
        @(negedge clk_i);
        chk(int'(drop_cnt_o) == d0 + 2, "R9 drop2", int'(drop_cnt_o), d0 + 2);
        chk(busy_o, "R8 still busy", int'(busy_o), 1);
        for (int e = 0; e < 8; e++) begin
            read_event(ev_exp, tns[e], 6, 40, e == 3, "R7 order"); ev_exp++;
        end
        repeat (3) @(negedge clk_i);
        chk(!busy_o, "R8 drained", int'(busy_o), 0);
        chk(!rd_valid_o, "R7 drained", int'(rd_valid_o), 0);
    endtask

    task automatic t_levels();
        int bases [5] = '{0, 200, 201, 1000, 4000};
        int exps  [5] = '{0, 0, 1, 4, 7};
        for (int k = 0; k < 5; k++) begin
            logic [NCH*12-1:0] v;
            for (int c = 0; c < NCH; c++) v[c*12 +: 12] = 12'(bases[k] + c);
            push_raw(v, k == 3);
            @(negedge clk_i);
            for (int c = 0; c < NCH; c++)
                chk(int'(level_o[c*3 +: 3]) == exps[k], "R1 R2 level",
                    int'(level_o[c*3 +: 3]), exps[k]);
        end
    endtask

    initial begin
        rst_ni = 1'b0; half_vld_i = 1'b0; half_i = '0; trig_i = 1'b0;
        delay_i = 8'd40; win_i = 5'd6; rd_ready_i = 1'b0;
        for (int c = 0; c < NCH; c++)
            for (int l = 0; l < 7; l++)
                thr_i[(c*7+l)*12 +: 12] = 12'(200*(l+1) + c);
        repeat (4) @(negedge clk_i);
        t_reset();
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_delay();
        t_window();
        t_ignore();
        t_overflow();
        t_levels();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule